// File: doc/BRIEF.md
# Streaming Packet Buffer Pair

This block holds the payload of one radio packet in each direction. A 16-byte transmit store sits between a host byte-write port and a byte-serial radio consumer. A 16-byte receive store sits between a byte-serial radio producer and a host byte-read port. A packet that fits in the store is loaded in one burst and then leaves with no further host action. Each direction also has a per-packet byte counter with an 8-bit length, separate from the fill level of its store. A packet of up to 255 bytes can therefore stream through the small store, with the host topping up or draining it whenever a threshold interrupt fires.

The host starts a transmit packet with a go pulse that captures the length. The radio starts a receive packet with a start pulse that carries the length from the received header. While the radio is exchanging acknowledge frames it raises an acknowledge-mode input. Radio strobes are then ignored, so neither store nor either counter changes.

Top module: `pktbuf_pair`

## Requirements
- R1: Each store holds 16 bytes. `tx_level` and `rx_level` report the number of bytes held (0 to 16), and a host write into a full transmit store with no radio take in the same cycle is ignored.
- R2: Bytes leave each store in the order they entered. `rad_tx_data` shows the oldest transmit byte and `host_rx_data` shows the oldest receive byte.
- R3: A `tx_go` pulse captures `tx_len`, clears `tx_sent`, `tx_done` and `tx_underflow`, and makes `tx_busy` high in the next cycle when the length is nonzero. It does not discard stored bytes. `rad_tx_valid` is high exactly when `tx_busy` is high and the store is not empty.
- R4: Each `rad_tx_take` while busy and not empty removes one byte and increments `tx_sent`. The take that brings `tx_sent` to the length sets `tx_done`, clears `tx_busy` and resets both transmit pointers, so `tx_level` reads 0. A length of 0 sets `tx_done` one cycle after `tx_go`.
- R5: A `rad_tx_take` while busy with an empty store sets `tx_underflow` and does not advance `tx_sent`. The flag stays set until the next `tx_go`.
- R6: A `rad_rx_start` pulse captures `rad_rx_len`, resets both receive pointers and `rx_got`, and clears `rx_overflow` and `rx_done`. Each `rad_rx_put` while `rx_busy` is high increments `rx_got`. Reaching the length sets `rx_done`. Puts after that point are ignored.
- R7: A put into a full receive store, with no host read in the same cycle, drops the byte, sets the sticky `rx_overflow` flag and still increments `rx_got`. The flag stays set until the next `rad_rx_start`.
- R8: When a store is full, a write and a read in the same cycle both take effect, so the level stays at 16 and no overflow is flagged.
- R9: `irq_tx_space` is high when at least 8 transmit entries are free. `irq_rx_data` is high when at least 8 receive bytes are held.
- R10: While `rad_ack` is high, `rad_tx_take` and `rad_rx_put` have no effect on the levels, the counts or the flags.
- R11: After reset both levels and counts are 0, all flags are low, `irq_tx_space` is high and `rad_tx_valid` is low.
- R12: A transmit packet longer than the store (40 bytes) streams out complete and in order when the host keeps refilling during transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_tx_we | input | 1 | Host writes one transmit byte |
| host_tx_data | input | 8 | Transmit byte from host |
| tx_len | input | 8 | Transmit packet length, captured on tx_go |
| tx_go | input | 1 | Start transmit packet |
| host_rx_re | input | 1 | Host reads (pops) one receive byte |
| host_rx_data | output | 8 | Oldest receive byte |
| tx_level | output | 5 | Bytes held in transmit store |
| rx_level | output | 5 | Bytes held in receive store |
| tx_sent | output | 8 | Bytes of current transmit packet handed to radio |
| rx_got | output | 8 | Bytes of current receive packet delivered by radio |
| tx_busy | output | 1 | Transmit packet in progress |
| tx_done | output | 1 | Transmit packet complete |
| tx_underflow | output | 1 | Sticky: radio needed a byte from an empty store |
| rx_busy | output | 1 | Receive packet in progress |
| rx_done | output | 1 | Receive packet complete |
| rx_overflow | output | 1 | Sticky: radio wrote into a full store |
| irq_tx_space | output | 1 | At least 8 transmit entries free |
| irq_rx_data | output | 1 | At least 8 receive bytes held |
| rad_ack | input | 1 | Radio is handling acknowledge frames; radio strobes ignored |
| rad_tx_take | input | 1 | Radio consumes the shown transmit byte |
| rad_tx_data | output | 8 | Oldest transmit byte for radio |
| rad_tx_valid | output | 1 | A transmit byte is available |
| rad_rx_start | input | 1 | Radio begins a receive packet |
| rad_rx_len | input | 8 | Receive packet length, captured on rad_rx_start |
| rad_rx_put | input | 1 | Radio delivers one receive byte |
| rad_rx_data | input | 8 | Receive byte from radio |

## Verification
A host write and a radio take can land on the transmit store in the same cycle, and a radio put and a host read can land on the receive store in the same cycle. The interesting case is when the store is full. The bench triggers this on the transmit side at the start of a 40-byte stream, writing and taking together on a full store. It triggers it on the receive side by putting the seventeenth byte while reading. It then checks that the level stays at 16, that no overflow is raised, and that the byte order on the far side keeps the new byte and loses the popped one only.

// File: rtl/pktbuf_pkg.sv
// Shared types for the streaming packet buffer pair.
package pktbuf_pkg;
    // Progress of one packet through a length counter.
    typedef enum logic [1:0] {
        PC_IDLE = 2'd0,
        PC_RUN  = 2'd1,
        PC_DONE = 2'd2
    } pc_state_e;
endpackage

// File: rtl/pb_byte_fifo.sv
// Circular byte store with fill level.
// Assumes: flush has priority over push and pop; push into a full store
// is accepted only when a pop is accepted in the same cycle.
module pb_byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

    // Advance pointers and level; flush returns both pointers to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/pb_pkt_counter.sv
// Per-packet byte counter, independent of buffer fill.
// Assumes: start wins over step; a zero length completes at once.
module pb_pkt_counter #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    input  logic             step,
    output logic [LEN_W-1:0] count,
    output logic             last,
    output logic             running,
    output logic             done
);
    import pktbuf_pkg::*;

    pc_state_e        state;
    logic [LEN_W-1:0] len_q;

    assign running = (state == PC_RUN);
    assign done    = (state == PC_DONE);
    assign last    = running && (({1'b0, count} + 1'b1) == {1'b0, len_q});

    // Capture length on start, count steps while running, stop at length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PC_IDLE;
            len_q <= '0;
            count <= '0;
        end else if (start) begin
            len_q <= len_in;
            count <= '0;
            state <= (len_in == '0) ? PC_DONE : PC_RUN;
        end else if (step && running) begin
            count <= count + 1'b1;
            if (last) state <= PC_DONE;
        end
    end
endmodule

// File: rtl/pktbuf_pair.sv
// Transmit and receive packet buffers with per-packet length tracking,
// threshold interrupts and sticky error flags.
// Assumes: THRESH <= DEPTH; radio strobes are ignored while rad_ack is high.
module pktbuf_pair #(
    parameter int DW     = 8,
    parameter int DEPTH  = 16,
    parameter int LEN_W  = 8,
    parameter int THRESH = 8,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_tx_we,
    input  logic [DW-1:0]    host_tx_data,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             tx_go,
    input  logic             host_rx_re,
    output logic [DW-1:0]    host_rx_data,
    output logic [LW-1:0]    tx_level,
    output logic [LW-1:0]    rx_level,
    output logic [LEN_W-1:0] tx_sent,
    output logic [LEN_W-1:0] rx_got,
    output logic             tx_busy,
    output logic             tx_done,
    output logic             tx_underflow,
    output logic             rx_busy,
    output logic             rx_done,
    output logic             rx_overflow,
    output logic             irq_tx_space,
    output logic             irq_rx_data,
    input  logic             rad_ack,
    input  logic             rad_tx_take,
    output logic [DW-1:0]    rad_tx_data,
    output logic             rad_tx_valid,
    input  logic             rad_rx_start,
    input  logic [LEN_W-1:0] rad_rx_len,
    input  logic             rad_rx_put,
    input  logic [DW-1:0]    rad_rx_data
);
    logic tx_full, tx_empty, tx_last, tx_take_ok, tx_step, tx_flush;
    logic rx_full, rx_empty, rx_last, rx_put_ok;

    // Transmit side qualification.
    assign tx_take_ok   = rad_tx_take && !rad_ack && tx_busy && !tx_go;
    assign tx_step      = tx_take_ok && !tx_empty;
    assign tx_flush     = tx_step && tx_last;
    assign rad_tx_valid = tx_busy && !tx_empty;

    pb_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(host_tx_we), .din(host_tx_data), .pop(tx_step),
        .dout(rad_tx_data), .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    pb_pkt_counter #(.LEN_W(LEN_W)) tx_cnt_i (
        .clk(clk), .rst_n(rst_n), .start(tx_go), .len_in(tx_len),
        .step(tx_step), .count(tx_sent), .last(tx_last),
        .running(tx_busy), .done(tx_done)
    );

    // Sticky underflow: radio wanted a byte the store did not have.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_go)                tx_underflow <= 1'b0;
        else if (tx_take_ok && tx_empty)    tx_underflow <= 1'b1;
    end

    // Receive side qualification.
    assign rx_put_ok = rad_rx_put && !rad_ack && rx_busy && !rad_rx_start;

    pb_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(rad_rx_start),
        .push(rx_put_ok), .din(rad_rx_data), .pop(host_rx_re),
        .dout(host_rx_data), .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    pb_pkt_counter #(.LEN_W(LEN_W)) rx_cnt_i (
        .clk(clk), .rst_n(rst_n), .start(rad_rx_start), .len_in(rad_rx_len),
        .step(rx_put_ok), .count(rx_got), .last(rx_last),
        .running(rx_busy), .done(rx_done)
    );

    // Sticky overflow: radio byte arrived with no room and no host read.
    always_ff @(posedge clk) begin
        if (!rst_n || rad_rx_start)                     rx_overflow <= 1'b0;
        else if (rx_put_ok && rx_full && !host_rx_re)   rx_overflow <= 1'b1;
    end

    // Threshold interrupts derived from fill levels.
    assign irq_tx_space = (LW'(DEPTH) - tx_level) >= LW'(THRESH);
    assign irq_rx_data  = rx_level >= LW'(THRESH);
endmodule

// File: rtl/pktbuf_chk.sv
// Property checker for pktbuf_pair, bound to every instance.
module pktbuf_chk #(
    parameter int DEPTH = 16,
    parameter int LEN_W = 8,
    parameter int LW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_tx_we,
    input logic             host_rx_re,
    input logic             tx_go,
    input logic             rad_ack,
    input logic             rad_rx_start,
    input logic [LW-1:0]    tx_level,
    input logic [LW-1:0]    rx_level,
    input logic [LEN_W-1:0] tx_sent,
    input logic [LEN_W-1:0] rx_got,
    input logic             tx_busy,
    input logic             tx_done,
    input logic             tx_underflow,
    input logic             rx_overflow
);
    // R1: levels never exceed the store size.
    p_level_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

    // R3: go clears the sent count and the underflow flag.
    p_go_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |=> (tx_sent == '0) && !tx_underflow);

    // R4: busy and done never both high.
    p_busy_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_busy && tx_done));

    // R5: underflow holds until the next go.
    p_ufl_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underflow && !tx_go) |=> tx_underflow);

    // R6: radio start empties the receive store and count.
    p_rx_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rad_rx_start |=> (rx_level == '0) && (rx_got == '0) && !rx_overflow);

    // R7: overflow holds until the next receive start.
    p_ofl_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && !rad_rx_start) |=> rx_overflow);

    // R10: with only radio strobes in acknowledge mode nothing moves.
    p_ack_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rad_ack && !host_tx_we && !host_rx_re && !tx_go && !rad_rx_start)
        |=> ($stable(tx_level) && $stable(rx_level) && $stable(tx_sent) && $stable(rx_got)));
endmodule

bind pktbuf_pair pktbuf_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .LW(LW)) chk_i (
    .clk(clk), .rst_n(rst_n), .host_tx_we(host_tx_we), .host_rx_re(host_rx_re),
    .tx_go(tx_go), .rad_ack(rad_ack), .rad_rx_start(rad_rx_start),
    .tx_level(tx_level), .rx_level(rx_level), .tx_sent(tx_sent), .rx_got(rx_got),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_underflow(tx_underflow),
    .rx_overflow(rx_overflow)
);

// File: tb/pktbuf_pair_tb.sv
// Directed bench for pktbuf_pair: one task per scenario.
module pktbuf_pair_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_tx_we = 1'b0;
    logic [7:0] host_tx_data = '0;
    logic [7:0] tx_len = '0;
    logic       tx_go = 1'b0;
    logic       host_rx_re = 1'b0;
    logic [7:0] host_rx_data;
    logic [4:0] tx_level, rx_level;
    logic [7:0] tx_sent, rx_got;
    logic       tx_busy, tx_done, tx_underflow, rx_busy, rx_done, rx_overflow;
    logic       irq_tx_space, irq_rx_data;
    logic       rad_ack = 1'b0;
    logic       rad_tx_take = 1'b0;
    logic [7:0] rad_tx_data;
    logic       rad_tx_valid;
    logic       rad_rx_start = 1'b0;
    logic [7:0] rad_rx_len = '0;
    logic       rad_rx_put = 1'b0;
    logic [7:0] rad_rx_data = '0;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pktbuf_pair dut_i (
        .clk(clk), .rst_n(rst_n), .host_tx_we(host_tx_we), .host_tx_data(host_tx_data),
        .tx_len(tx_len), .tx_go(tx_go), .host_rx_re(host_rx_re), .host_rx_data(host_rx_data),
        .tx_level(tx_level), .rx_level(rx_level), .tx_sent(tx_sent), .rx_got(rx_got),
        .tx_busy(tx_busy), .tx_done(tx_done), .tx_underflow(tx_underflow),
        .rx_busy(rx_busy), .rx_done(rx_done), .rx_overflow(rx_overflow),
        .irq_tx_space(irq_tx_space), .irq_rx_data(irq_rx_data),
        .rad_ack(rad_ack), .rad_tx_take(rad_tx_take), .rad_tx_data(rad_tx_data),
        .rad_tx_valid(rad_tx_valid), .rad_rx_start(rad_rx_start), .rad_rx_len(rad_rx_len),
        .rad_rx_put(rad_rx_put), .rad_rx_data(rad_rx_data)
    );

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 11) & 8'hFF);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic host_wr(logic [7:0] b);
        host_tx_we = 1'b1; host_tx_data = b; tick(); host_tx_we = 1'b0;
    endtask

    task automatic go(logic [7:0] n);
        tx_go = 1'b1; tx_len = n; tick(); tx_go = 1'b0;
    endtask

    task automatic take();
        rad_tx_take = 1'b1; tick(); rad_tx_take = 1'b0;
    endtask

    task automatic put(logic [7:0] b);
        rad_rx_put = 1'b1; rad_rx_data = b; tick(); rad_rx_put = 1'b0;
    endtask

    task automatic rd();
        host_rx_re = 1'b1; tick(); host_rx_re = 1'b0;
    endtask

    task automatic t_reset();
        chk(tx_level == 0 && rx_level == 0, "R11 levels", tx_level, 0);
        chk(tx_sent == 0 && rx_got == 0, "R11 counts", tx_sent, 0);
        chk(!tx_underflow && !rx_overflow && !tx_done && !rx_done, "R11 flags", tx_underflow, 0);
        chk(irq_tx_space == 1, "R11 irq_tx_space", irq_tx_space, 1);
        chk(rad_tx_valid == 0 && irq_rx_data == 0, "R11 valid", rad_tx_valid, 0);
    endtask

    task automatic t_short_tx();
        for (int i = 0; i < 5; i++) host_wr(pat(i));
        chk(tx_level == 5, "R1 level after 5", tx_level, 5);
        chk(rad_tx_valid == 0, "R3 valid before go", rad_tx_valid, 0);
        go(8'd5);
        chk(tx_busy == 1 && rad_tx_valid == 1, "R3 busy after go", tx_busy, 1);
        for (int i = 0; i < 5; i++) begin
            chk(rad_tx_data == pat(i), "R2 tx order", rad_tx_data, pat(i));
            take();
        end
        chk(tx_done == 1 && tx_busy == 0, "R4 done", tx_done, 1);
        chk(tx_sent == 5, "R4 sent", tx_sent, 5);
        chk(tx_level == 0, "R4 pointers reset", tx_level, 0);
    endtask

    task automatic t_full_tx();
        for (int i = 0; i < 17; i++) begin
            host_wr(pat(100 + i));
            if (i == 7) chk(irq_tx_space == 1, "R9 space at 8 free", irq_tx_space, 1);
            if (i == 8) chk(irq_tx_space == 0, "R9 space at 7 free", irq_tx_space, 0);
        end
        chk(tx_level == 16, "R1 full write ignored", tx_level, 16);
        go(8'd16);
        for (int i = 0; i < 16; i++) begin
            chk(rad_tx_data == pat(100 + i), "R2 full order", rad_tx_data, pat(100 + i));
            take();
        end
        chk(tx_done == 1 && tx_level == 0, "R4 full drain", tx_level, 0);
    endtask

    task automatic t_len0();
        go(8'd0);
        chk(tx_done == 1 && tx_busy == 0, "R4 zero length", tx_done, 1);
    endtask

    task automatic t_underflow();
        go(8'd3);
        take();
        chk(tx_underflow == 1, "R5 underflow set", tx_underflow, 1);
        chk(tx_sent == 0, "R5 no advance", tx_sent, 0);
        host_wr(pat(7));
        take();
        chk(tx_underflow == 1, "R5 sticky", tx_underflow, 1);
        chk(tx_sent == 1, "R5 advance with data", tx_sent, 1);
        go(8'd1);
        chk(tx_underflow == 0 && tx_sent == 0, "R3 go clears", tx_underflow, 0);
    endtask

    task automatic t_long_tx();
        int wr;
        for (int i = 0; i < 16; i++) host_wr(pat(200 + i));
        wr = 16;
        go(8'd40);
        for (int i = 0; i < 40; i++) begin
            chk(rad_tx_valid == 1, "R12 valid", rad_tx_valid, 1);
            chk(rad_tx_data == pat(200 + i), "R12 stream order", rad_tx_data, pat(200 + i));
            rad_tx_take = 1'b1;
            if (wr < 40) begin
                host_tx_we = 1'b1; host_tx_data = pat(200 + wr); wr++;
            end
            tick();
            rad_tx_take = 1'b0; host_tx_we = 1'b0;
            if (i == 0) chk(tx_level == 16, "R8 tx full write+take", tx_level, 16);
        end
        chk(tx_done == 1 && tx_sent == 40, "R12 long done", tx_sent, 40);
        chk(tx_underflow == 0 && tx_level == 0, "R12 no underflow", tx_underflow, 0);
    endtask

    task automatic t_rx();
        rad_rx_start = 1'b1; rad_rx_len = 8'd20; tick(); rad_rx_start = 1'b0;
        chk(rx_busy == 1 && rx_level == 0, "R6 start", rx_busy, 1);
        for (int k = 0; k < 16; k++) begin
            put(pat(50 + k));
            if (k == 6) chk(irq_rx_data == 0, "R9 rx irq at 7", irq_rx_data, 0);
            if (k == 7) chk(irq_rx_data == 1, "R9 rx irq at 8", irq_rx_data, 1);
        end
        chk(rx_level == 16, "R1 rx full", rx_level, 16);
        chk(host_rx_data == pat(50), "R2 rx head", host_rx_data, pat(50));
        rad_rx_put = 1'b1; rad_rx_data = pat(66); host_rx_re = 1'b1;
        tick();
        rad_rx_put = 1'b0; host_rx_re = 1'b0;
        chk(rx_level == 16 && rx_overflow == 0, "R8 rx full put+read", rx_overflow, 0);
        put(pat(67));
        chk(rx_overflow == 1, "R7 overflow", rx_overflow, 1);
        chk(rx_level == 16 && rx_got == 18, "R7 count advances", rx_got, 18);
        for (int k = 1; k < 17; k++) begin
            chk(host_rx_data == pat(50 + k), "R2 rx order", host_rx_data, pat(50 + k));
            rd();
        end
        put(pat(68));
        put(pat(69));
        chk(rx_done == 1 && rx_got == 20, "R6 rx done", rx_got, 20);
        chk(rx_overflow == 1, "R7 overflow sticky", rx_overflow, 1);
        put(pat(70));
        chk(rx_level == 2 && rx_got == 20, "R6 put after done ignored", rx_level, 2);
        chk(host_rx_data == pat(68), "R6 kept bytes", host_rx_data, pat(68));
    endtask

    task automatic t_ack();
        rad_rx_start = 1'b1; rad_rx_len = 8'd4; tick(); rad_rx_start = 1'b0;
        chk(rx_overflow == 0 && rx_level == 0, "R6 restart clears", rx_overflow, 0);
        put(pat(90));
        host_wr(pat(91));
        host_wr(pat(92));
        go(8'd2);
        rad_ack = 1'b1;
        put(pat(93));
        take();
        chk(rx_level == 1 && rx_got == 1, "R10 rx unchanged", rx_level, 1);
        chk(tx_level == 2 && tx_sent == 0, "R10 tx unchanged", tx_level, 2);
        chk(tx_underflow == 0 && rx_overflow == 0, "R10 flags unchanged", tx_underflow, 0);
        rad_ack = 1'b0;
        chk(rad_tx_data == pat(91), "R10 tx head kept", rad_tx_data, pat(91));
        take();
        take();
        chk(tx_done == 1 && tx_level == 0, "R10 tx resumes", tx_done, 1);
        chk(host_rx_data == pat(90), "R10 rx head kept", host_rx_data, pat(90));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_short_tx();
        t_full_tx();
        t_len0();
        t_underflow();
        take();
        t_long_tx();
        t_rx();
        t_ack();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule